// File: doc/BRIEF.md
# Carry-Flag Bit Manipulation Unit

This block carries out the single-bit instructions of a small 8-bit CPU, those that combine the carry flag with one bit of a byte in memory. The sequencer issues an operation with a 16-bit operand word, a 3-bit operation code, a complement select and the current carry. The block splits the operand into a byte address and a bit index. It requests the byte from memory and waits for the data. Depending on the operation, it then updates the carry or writes a modified byte back.

The operand uses its top three bits as the bit index, so the byte address is 13 bits wide. The sequencer stalls while `busy_o` is high. It takes the result when `done_o` pulses, at which point `carry_o` holds the new carry. Operation codes (`op_i`): 0 OR into carry, 1 AND into carry, 2 XOR into carry, 3 load carry from bit, 4 store carry into bit, 5 invert bit. Codes 6 and 7 are not legal.

Top module: `cbit_unit`

## Requirements
- R1: After reset `busy_o`, `done_o`, `mem_rd_req_o`, `mem_wr_req_o` and `carry_o` are all 0.
- R2: During a read, `mem_addr_o` equals operand bits 12:0 and `bit_idx_o` equals operand bits 15:13. Both stay stable until the data is accepted.
- R3: Op 0 gives carry = C | (b ^ inv), where b is the selected bit and inv is `inv_i`.
- R4: Op 1 gives carry = C & (b ^ inv).
- R5: Op 2 gives carry = C ^ b. `inv_i` has no effect on this op.
- R6: Op 3 gives carry = b.
- R7: Op 4 writes back the read byte with the selected bit set to C. It writes one cycle after an idle cycle and leaves the carry unchanged.
- R8: Op 5 writes back the read byte with the selected bit inverted, in the cycle right after the read completes. The carry is unchanged.
- R9: Ops 0, 2 and 4 spend exactly one idle cycle after the read. Ops 1, 3 and 5 spend none.
- R10: Ops 0 to 3 never assert `mem_wr_req_o`.
- R11: `mem_rd_req_o` is held, for any number of wait cycles, until `mem_rd_valid_i` is seen. Read and write requests are never high together.
- R12: `start_i` is ignored while an operation is in progress.
- R13: Illegal codes 6 and 7 make no memory access. They pulse `done_o` in the cycle after the start and leave the carry equal to `carry_i`.
- R14: `busy_o` is high from the cycle after start until `done_o`. `done_o` is a one-cycle pulse with `busy_o` low, followed by idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue an operation (taken only when idle) |
| op_i | input | 3 | Operation code |
| inv_i | input | 1 | Use complemented bit for ops 0 and 1 |
| operand_i | input | 16 | Bit index (15:13) and byte address (12:0) |
| carry_i | input | 1 | Carry in at issue |
| mem_rd_req_o | output | 1 | Read request |
| mem_addr_o | output | 13 | Byte address |
| bit_idx_o | output | 3 | Selected bit index |
| mem_rd_valid_i | input | 1 | Read data valid |
| mem_rd_data_i | input | 8 | Read data |
| mem_wr_req_o | output | 1 | One-cycle write strobe |
| mem_wr_data_o | output | 8 | Modified byte to write |
| carry_o | output | 1 | Resulting carry |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |

## Verification
A wrong sequencer state shows up at once as a read or write strobe, or a busy or done level, in the wrong cycle. The bench compares all four of these on every clock against a behavioural timeline, so such a slip is caught in the cycle it happens. A wrong captured byte or bit index shows up on the write data in the single write cycle, or on the carry at the done pulse, within one to three cycles of the read. A carry register that drifts for a write-back operation is caught on the next clock by the stability check.

// File: rtl/cbit_pkg.sv
package cbit_pkg;
  typedef logic [2:0] cb_op_t;

  localparam cb_op_t CB_OR1  = 3'd0;
  localparam cb_op_t CB_AND1 = 3'd1;
  localparam cb_op_t CB_EOR1 = 3'd2;
  localparam cb_op_t CB_LDC  = 3'd3;
  localparam cb_op_t CB_STC  = 3'd4;
  localparam cb_op_t CB_NOT1 = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_PAUSE, ST_WRITE, ST_DONE
  } cb_state_e;

  function automatic logic op_legal(cb_op_t op);
    return op <= CB_NOT1;
  endfunction

  function automatic logic op_pause(cb_op_t op);
    return (op == CB_OR1) || (op == CB_EOR1) || (op == CB_STC);
  endfunction

  function automatic logic op_writes(cb_op_t op);
    return (op == CB_STC) || (op == CB_NOT1);
  endfunction

  // carry committed when read data arrives
  function automatic logic op_early_c(cb_op_t op);
    return (op == CB_AND1) || (op == CB_LDC);
  endfunction

  // carry committed at the end of the idle cycle
  function automatic logic op_late_c(cb_op_t op);
    return (op == CB_OR1) || (op == CB_EOR1);
  endfunction
endpackage

// File: rtl/cbit_split.sv
module cbit_split #(
  parameter int ADDR_W = 13,
  parameter int IDX_W  = 3,
  localparam int OPND_W = ADDR_W + IDX_W
) (
  input  logic [OPND_W-1:0] operand_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  idx_o
);
  assign addr_o = operand_i[ADDR_W-1:0];
  assign idx_o  = operand_i[OPND_W-1:ADDR_W];
endmodule

// File: rtl/cbit_alu.sv
module cbit_alu
  import cbit_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  cb_op_t            op_i,
  input  logic              inv_i,
  input  logic              carry_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              carry_o,
  output logic [DATA_W-1:0] byte_o
);
  logic sel_bit;
  logic new_bit;

  assign sel_bit = byte_i[idx_i];

  always_comb begin
    carry_o = carry_i;
    new_bit = sel_bit;
    case (op_i)
      CB_OR1:  carry_o = carry_i | (sel_bit ^ inv_i);
      CB_AND1: carry_o = carry_i & (sel_bit ^ inv_i);
      CB_EOR1: carry_o = carry_i ^ sel_bit;
      CB_LDC:  carry_o = sel_bit;
      CB_STC:  new_bit = carry_i;
      CB_NOT1: new_bit = ~sel_bit;
      default: ;
    endcase
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign byte_o[g] = (idx_i == IDX_W'(g)) ? new_bit : byte_i[g];
  end
endmodule

// File: rtl/cbit_seq.sv
module cbit_seq
  import cbit_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  cb_op_t    op_new_i,
  input  cb_op_t    op_q_i,
  input  logic      rd_valid_i,
  output cb_state_e state_o
);
  cb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = op_legal(op_new_i) ? ST_READ : ST_DONE;
      ST_READ:  if (rd_valid_i) begin
                  if (op_pause(op_q_i))       state_d = ST_PAUSE;
                  else if (op_writes(op_q_i)) state_d = ST_WRITE;
                  else                        state_d = ST_DONE;
                end
      ST_PAUSE: state_d = op_writes(op_q_i) ? ST_WRITE : ST_DONE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cbit_unit.sv
module cbit_unit
  import cbit_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int OPND_W = ADDR_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic              inv_i,
  input  logic [OPND_W-1:0] operand_i,
  input  logic              carry_i,
  output logic              mem_rd_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [IDX_W-1:0]  bit_idx_o,
  input  logic              mem_rd_valid_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              mem_wr_req_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  output logic              carry_o,
  output logic              busy_o,
  output logic              done_o
);
  cb_state_e         state;
  logic [OPND_W-1:0] opnd_q;
  cb_op_t            op_q;
  logic              inv_q;
  logic              carry_q;
  logic [DATA_W-1:0] byte_q;
  logic [IDX_W-1:0]  idx;
  logic              start_acc, rd_acc;
  logic [DATA_W-1:0] alu_in, alu_byte;
  logic              alu_carry;

  assign start_acc = start_i && (state == ST_IDLE);
  assign rd_acc    = (state == ST_READ) && mem_rd_valid_i;

  cbit_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .op_new_i   (op_i),
    .op_q_i     (op_q),
    .rd_valid_i (mem_rd_valid_i),
    .state_o    (state)
  );

  cbit_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split (
    .operand_i (opnd_q),
    .addr_o    (mem_addr_o),
    .idx_o     (idx)
  );

  assign alu_in = rd_acc ? mem_rd_data_i : byte_q;

  cbit_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (op_q),
    .inv_i   (inv_q),
    .carry_i (carry_q),
    .idx_i   (idx),
    .byte_i  (alu_in),
    .carry_o (alu_carry),
    .byte_o  (alu_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opnd_q  <= '0;
      op_q    <= CB_OR1;
      inv_q   <= 1'b0;
      carry_q <= 1'b0;
      byte_q  <= '0;
    end else begin
      if (start_acc) begin
        opnd_q  <= operand_i;
        op_q    <= op_i;
        inv_q   <= inv_i;
        carry_q <= carry_i;
      end else if ((rd_acc && op_early_c(op_q)) ||
                   ((state == ST_PAUSE) && op_late_c(op_q))) begin
        carry_q <= alu_carry;
      end
      if (rd_acc) byte_q <= mem_rd_data_i;
    end
  end

  assign bit_idx_o     = idx;
  assign mem_rd_req_o  = (state == ST_READ);
  assign mem_wr_req_o  = (state == ST_WRITE);
  assign mem_wr_data_o = (state == ST_WRITE) ? alu_byte : '0;
  assign carry_o       = carry_q;
  assign busy_o        = (state == ST_READ) || (state == ST_PAUSE) || (state == ST_WRITE);
  assign done_o        = (state == ST_DONE);
endmodule

// File: rtl/cbit_unit_chk.sv
module cbit_unit_chk
  import cbit_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2:0]        op_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_rd_req_o,
  input logic              mem_rd_valid_i,
  input logic              mem_wr_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [IDX_W-1:0]  bit_idx_o,
  input logic              carry_o
);
  cb_op_t cap_op;
  logic   issue;

  assign issue = start_i && !busy_o && !done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_op <= CB_OR1;
    else if (issue) cap_op <= op_i;
  end

  assert_wr_only_wb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_req_o |-> (cap_op == CB_STC || cap_op == CB_NOT1));

  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_req_o && !mem_rd_valid_i) |=> mem_rd_req_o);

  assert_rw_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_req_o && mem_wr_req_o));

  assert_addr_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_req_o && !mem_rd_valid_i) |=> ($stable(mem_addr_o) && $stable(bit_idx_o)));

  assert_done_pulse_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7 and R8: write-back ops keep the carry captured at issue
  assert_carry_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (cap_op == CB_STC || cap_op == CB_NOT1)) |=> $stable(carry_o));

  assert_illegal_no_mem_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && op_i > CB_NOT1) |=> (done_o && !mem_rd_req_o && !busy_o));
endmodule

bind cbit_unit cbit_unit_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/cbit_unit_tb_top.sv
module cbit_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        inv = 1'b0;
  logic [15:0] operand = '0;
  logic        cin = 1'b0;
  logic        rd_req, wr_req, cout, busy, done;
  logic [12:0] addr;
  logic [2:0]  bidx;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = '0;
  logic [7:0]  wr_data;

  int n_run = 0;
  int n_fail = 0;
  bit model_c = 1'b0;

  always #2 clk = ~clk;

  cbit_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .inv_i(inv),
    .operand_i(operand), .carry_i(cin), .mem_rd_req_o(rd_req), .mem_addr_o(addr),
    .bit_idx_o(bidx), .mem_rd_valid_i(rd_valid), .mem_rd_data_i(rd_data),
    .mem_wr_req_o(wr_req), .mem_wr_data_o(wr_data), .carry_o(cout),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // vector {rd, wr, busy, done, carry}
  task automatic chk_st(string req, string what, bit r, bit w, bit b, bit d, bit c);
    chk(req, what, int'({rd_req, wr_req, busy, done, cout}), int'({r, w, b, d, c}));
  endtask

  function automatic string op_tag(logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R13";
    endcase
  endfunction

  task automatic run_op(logic [2:0] o, bit iv, logic [15:0] opnd, bit c,
                        logic [7:0] data, int waits, bit intrude);
    bit b, cn, pause, wb, legal;
    logic [7:0] wexp;
    int idx;
    idx   = int'(opnd[15:13]);
    b     = data[idx];
    legal = (o <= 3'd5);
    pause = (o == 3'd0) || (o == 3'd2) || (o == 3'd4);
    wb    = (o == 3'd4) || (o == 3'd5);
    case (o)
      3'd0: cn = c | (b ^ iv);
      3'd1: cn = c & (b ^ iv);
      3'd2: cn = c ^ b;
      3'd3: cn = b;
      default: cn = c;
    endcase
    wexp = data;
    if (o == 3'd4) wexp[idx] = c;
    if (o == 3'd5) wexp[idx] = ~b;

    @(negedge clk);
    chk_st("R14", "idle before issue", 0, 0, 0, 0, model_c);
    start = 1'b1; op = o; inv = iv; operand = opnd; cin = c;
    @(negedge clk);
    start = 1'b0; op = 3'd3; inv = ~iv; operand = ~opnd; cin = ~c;
    if (!legal) begin
      chk_st("R13", "illegal completes", 0, 0, 0, 1, c);
      model_c = c;
      return;
    end
    for (int w = 0; w <= waits; w++) begin
      chk_st("R11", "read held", 1, 0, 1, 0, c);
      chk("R2", "byte address", int'(addr), int'(opnd[12:0]));
      chk("R2", "bit index", int'(bidx), idx);
      rd_valid = (w == waits);
      rd_data  = (w == waits) ? data : ~data;
      if (intrude) start = 1'b1;
      @(negedge clk);
      rd_valid = 1'b0;
      rd_data  = 8'h00;
      start    = 1'b0;
    end
    if (pause) begin
      chk_st("R9", "idle cycle after read", 0, 0, 1, 0, c);
      @(negedge clk);
    end
    if (wb) begin
      chk_st(op_tag(o), "write strobe", 0, 1, 1, 0, c);
      chk(op_tag(o), "write data", int'(wr_data), int'(wexp));
      @(negedge clk);
    end
    if (!wb) chk("R10", "no write at done", int'(wr_req), 0);
    chk_st(op_tag(o), "done and carry", 0, 0, 0, 1, cn);
    model_c = cn;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL R14 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_st("R1", "reset state", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_st("R1", "after reset release", 0, 0, 0, 0, 0);

    run_op(3'd0, 1'b0, {3'd7, 13'h1abc}, 1'b0, 8'h80, 0, 1'b0); // R3 -> 1
    run_op(3'd0, 1'b1, {3'd7, 13'h0001}, 1'b0, 8'h80, 1, 1'b0); // R3 inv -> 0
    run_op(3'd0, 1'b1, {3'd2, 13'h1fff}, 1'b0, 8'hfb, 0, 1'b0); // R3 inv -> 1
    run_op(3'd1, 1'b0, {3'd3, 13'h0123}, 1'b1, 8'h08, 0, 1'b0); // R4 -> 1
    run_op(3'd1, 1'b1, {3'd3, 13'h0123}, 1'b1, 8'h08, 2, 1'b0); // R4 inv -> 0
    run_op(3'd1, 1'b0, {3'd0, 13'h0777}, 1'b0, 8'hff, 0, 1'b0); // R4 c=0 -> 0
    run_op(3'd2, 1'b0, {3'd5, 13'h0400}, 1'b1, 8'h20, 2, 1'b0); // R5 -> 0
    run_op(3'd2, 1'b1, {3'd5, 13'h0400}, 1'b0, 8'h20, 0, 1'b0); // R5 inv ignored -> 1
    run_op(3'd3, 1'b0, {3'd0, 13'h0002}, 1'b1, 8'hfe, 0, 1'b0); // R6 -> 0
    run_op(3'd3, 1'b1, {3'd6, 13'h1000}, 1'b0, 8'h40, 1, 1'b0); // R6 -> 1
    run_op(3'd4, 1'b0, {3'd4, 13'h0aaa}, 1'b1, 8'h00, 0, 1'b0); // R7 set
    run_op(3'd4, 1'b0, {3'd1, 13'h0555}, 1'b0, 8'hff, 3, 1'b0); // R7 clear
    run_op(3'd5, 1'b0, {3'd6, 13'h1234}, 1'b1, 8'h5a, 0, 1'b0); // R8
    run_op(3'd5, 1'b1, {3'd0, 13'h0000}, 1'b0, 8'h01, 3, 1'b0); // R8
    run_op(3'd1, 1'b0, {3'd2, 13'h0321}, 1'b1, 8'h04, 2, 1'b1); // R12 start during read
    run_op(3'd5, 1'b0, {3'd7, 13'h0042}, 1'b0, 8'h00, 1, 1'b1); // R12
    run_op(3'd6, 1'b0, {3'd1, 13'h0011}, 1'b1, 8'h00, 0, 1'b0); // R13
    run_op(3'd7, 1'b1, {3'd2, 13'h0022}, 1'b0, 8'h00, 0, 1'b0); // R13
    @(negedge clk);
    chk_st("R14", "idle after last op", 0, 0, 0, 0, model_c);
    @(negedge clk);
    chk_st("R12", "no stray operation", 0, 0, 0, 0, model_c);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule